// File: doc/BRIEF.md
# Cursor Color-Key Pixel Substitution Stage

This block sits in a display pixel path. It takes a stream of graphics words, each 32 bits wide with the RGB pixel in the low 24 bits. It compares every pixel against a programmed key under a programmed mask. Mask bits that are zero take no part in the compare. When a pixel matches, the stage puts out one of two programmed cursor colors in place of the pixel. A programmed bit position inside the incoming 32-bit word picks between the two colors. Pixels that do not match pass through unchanged.

The stage has exactly one clock of latency. A small register port with write enable, byte address, write data and combinational read data holds the key, the bit position, the mask and the two colors. All of these reset to zero. A register write made in the middle of a stream first affects the pixel accepted in the cycle after the write.

Top module: `cursor_key_subst`

## Requirements
- R1: While `rst_n` is low, `pix_out_valid` and `pix_out_data` go to 0, and every register then reads back as 0.
- R2: Register map, 32-bit words at byte addresses: 50h control (key in bits 23:0, select position in bits 28:24), 54h mask (bits 23:0), 58h first color (bits 23:0), 5Ch second color (bits 23:0). Bits that are not defined read as 0. Any other address reads 0, and a write to it changes no register.
- R3: A pixel matches when ((pixel[23:0] ^ key) & mask) == 0. Pixel bits whose mask bit is 0 do not affect the result.
- R4: A matching pixel whose input-word bit at the select position is 0 is output as the first color (58h).
- R5: A matching pixel whose input-word bit at the select position is 1 is output as the second color (5Ch). The position ranges over 0..31, so positions 24..31 test the upper byte of the 32-bit input word.
- R6: A pixel that does not match is output as its own bits 23:0.
- R7: `pix_out_valid` equals `pix_in_valid` of the previous cycle, and `pix_out_data` then carries the result for the word accepted in that cycle.
- R8: In a cycle where no word is accepted, `pix_out_data` holds its previous value.
- R9: A register write in cycle N is used for pixels accepted in cycle N+1 and later. A pixel accepted in cycle N still sees the old value.
- R10: With a mask of 0, every valid pixel matches and is replaced by a cursor color.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| pix_in_valid | input | 1 | Input graphics word valid |
| pix_in_data | input | 32 | Input graphics word, pixel in bits 23:0 |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_data | output | 24 | Output pixel |

## Verification
Corruption of a stored key or mask shows as the wrong match decision. A matching pixel then leaves unchanged, or a passing pixel turns into a cursor color, on the very next output cycle. A wrong select position or color store shows as the wrong one of the two colors, also one cycle after the pixel enters. Register storage faults also appear at once on the combinational read port. The reference model therefore compares the valid flag, the output pixel and the read-back value on every cycle.

// File: rtl/ckey_pkg.sv
// Package: shared constants for the cursor color-key stage.
// Assumes byte addressing with 32-bit registers spaced four bytes apart.
package ckey_pkg;
    localparam int PIX_W_DEF   = 24;   // RGB pixel width
    localparam int WORD_W_DEF  = 32;   // incoming graphics word width
    localparam int REG_W_DEF   = 32;   // register word width
    localparam int ADDR_W_DEF  = 8;    // register address width
    localparam int NUM_SLOTS   = 4;    // control, mask, color 1, color 2
    localparam int SLOT_STRIDE = 4;    // bytes between registers

    // Register slot index, in address order from the base
    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_MASK = 2'd1,
        SLOT_COL1 = 2'd2,
        SLOT_COL2 = 2'd3
    } ckey_slot_e;
endpackage

// File: rtl/ckey_regfile.sv
// Module: ckey_regfile
// Holds key, select position, mask and two cursor colors. Writes land on the
// clock edge; reads are combinational. Undefined bits and unmapped addresses
// read as zero. Assumes REG_W >= PIX_W + OFS_W.
module ckey_regfile
    import ckey_pkg::*;
#(
    parameter int PIX_W     = PIX_W_DEF,
    parameter int WORD_W    = WORD_W_DEF,
    parameter int REG_W     = REG_W_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [REG_W-1:0]          rdata,
    output logic [PIX_W-1:0]          cfg_key,
    output logic [PIX_W-1:0]          cfg_mask,
    output logic [PIX_W-1:0]          cfg_col1,
    output logic [PIX_W-1:0]          cfg_col2,
    output logic [$clog2(WORD_W)-1:0] cfg_pos
);
    localparam int OFS_W = $clog2(WORD_W);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic [PIX_W-1:0]     field_q [NUM_SLOTS];
    logic [OFS_W-1:0]     pos_q;

    // Address decode: one comparator per register slot
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_dec
        assign slot_hit[k] = (addr == BASE_ADDR + ADDR_W'(SLOT_STRIDE * k));
    end

    // Storage: synchronous reset to zero, write on a decoded slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                field_q[k] <= '0;
            end
            pos_q <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (slot_hit[k]) begin
                    field_q[k] <= wdata[PIX_W-1:0];
                end
            end
            if (slot_hit[SLOT_CTRL]) begin
                pos_q <= wdata[PIX_W +: OFS_W];
            end
        end
    end

    // Read mux: undefined bits and unmapped addresses return zero
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (slot_hit[k]) begin
                rdata[PIX_W-1:0] = field_q[k];
            end
        end
        if (slot_hit[SLOT_CTRL]) begin
            rdata[PIX_W +: OFS_W] = pos_q;
        end
    end

    assign cfg_key  = field_q[SLOT_CTRL];
    assign cfg_mask = field_q[SLOT_MASK];
    assign cfg_col1 = field_q[SLOT_COL1];
    assign cfg_col2 = field_q[SLOT_COL2];
    assign cfg_pos  = pos_q;
endmodule

// File: rtl/ckey_match.sv
// Module: ckey_match
// Masked equality of a pixel against the key. Mask bits at zero drop the
// corresponding pixel bit from the compare. Purely combinational.
module ckey_match #(
    parameter int PIX_W = 24
) (
    input  logic [PIX_W-1:0] pixel,
    input  logic [PIX_W-1:0] key,
    input  logic [PIX_W-1:0] mask,
    output logic             hit
);
    logic [PIX_W-1:0] diff;

    // Per-bit masked difference
    for (genvar i = 0; i < PIX_W; i++) begin : g_bit
        assign diff[i] = (pixel[i] ^ key[i]) & mask[i];
    end

    // Match when no enabled bit differs
    assign hit = ~|diff;
endmodule

// File: rtl/ckey_select.sv
// Module: ckey_select
// Picks the outgoing pixel: on a hit, one of two colors chosen by the input
// word bit at position pos; otherwise the pixel bits of the word unchanged.
module ckey_select #(
    parameter int PIX_W  = 24,
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]         word,
    input  logic [$clog2(WORD_W)-1:0] pos,
    input  logic                      hit,
    input  logic [PIX_W-1:0]          col1,
    input  logic [PIX_W-1:0]          col2,
    output logic [PIX_W-1:0]          result
);
    logic sel_bit;

    // Bit that chooses the second color when set
    assign sel_bit = word[pos];

    // Output choice
    always_comb begin
        if (!hit) begin
            result = word[PIX_W-1:0];
        end else if (sel_bit) begin
            result = col2;
        end else begin
            result = col1;
        end
    end
endmodule

// File: rtl/cursor_key_subst.sv
// Module: cursor_key_subst (top)
// One-cycle pixel stage: masked key compare and cursor color substitution,
// with a register port for key, select position, mask and two colors.
// Assumes the input stream needs no back-pressure.
module cursor_key_subst
    import ckey_pkg::*;
#(
    parameter int PIX_W     = PIX_W_DEF,
    parameter int WORD_W    = WORD_W_DEF,
    parameter int REG_W     = REG_W_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              pix_in_valid,
    input  logic [WORD_W-1:0] pix_in_data,
    output logic              pix_out_valid,
    output logic [PIX_W-1:0]  pix_out_data
);
    localparam int OFS_W = $clog2(WORD_W);

    logic [PIX_W-1:0] cfg_key;
    logic [PIX_W-1:0] cfg_mask;
    logic [PIX_W-1:0] cfg_col1;
    logic [PIX_W-1:0] cfg_col2;
    logic [OFS_W-1:0] cfg_pos;
    logic             key_hit;
    logic [PIX_W-1:0] next_pix;
    logic             valid_q;
    logic [PIX_W-1:0] data_q;

    ckey_regfile #(
        .PIX_W(PIX_W), .WORD_W(WORD_W), .REG_W(REG_W),
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .cfg_key(cfg_key), .cfg_mask(cfg_mask), .cfg_col1(cfg_col1),
        .cfg_col2(cfg_col2), .cfg_pos(cfg_pos)
    );

    ckey_match #(.PIX_W(PIX_W)) u_match (
        .pixel(pix_in_data[PIX_W-1:0]), .key(cfg_key), .mask(cfg_mask),
        .hit(key_hit)
    );

    ckey_select #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_sel (
        .word(pix_in_data), .pos(cfg_pos), .hit(key_hit),
        .col1(cfg_col1), .col2(cfg_col2), .result(next_pix)
    );

    // Output stage: valid follows input by one cycle, data held when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= pix_in_valid;
            if (pix_in_valid) begin
                data_q <= next_pix;
            end
        end
    end

    assign pix_out_valid = valid_q;
    assign pix_out_data  = data_q;
endmodule

// File: rtl/ckey_checker.sv
// Module: ckey_checker
// Property checks for cursor_key_subst, attached by bind. Observes the ports
// and the register file outputs that feed the pixel path.
module ckey_checker #(
    parameter int PIX_W  = 24,
    parameter int WORD_W = 32,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [REG_W-1:0]          reg_wdata,
    input logic [REG_W-1:0]          reg_rdata,
    input logic                      pix_in_valid,
    input logic [WORD_W-1:0]         pix_in_data,
    input logic                      pix_out_valid,
    input logic [PIX_W-1:0]          pix_out_data,
    input logic [PIX_W-1:0]          key,
    input logic [PIX_W-1:0]          mask,
    input logic [PIX_W-1:0]          col1,
    input logic [PIX_W-1:0]          col2,
    input logic [$clog2(WORD_W)-1:0] pos
);
    localparam int OFS_W = $clog2(WORD_W);
    localparam logic [ADDR_W-1:0] MASK_ADDR = BASE_ADDR + ADDR_W'(4);

    logic in_hit;
    assign in_hit = (((pix_in_data[PIX_W-1:0] ^ key) & mask) == '0);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!pix_out_valid && pix_out_data == '0));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:PIX_W+OFS_W] == '0);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != BASE_ADDR) |-> (reg_rdata[REG_W-1:PIX_W] == '0));

    assert_color1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && in_hit && !pix_in_data[pos]) |=> pix_out_data == $past(col1));

    assert_color2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && in_hit && pix_in_data[pos]) |=> pix_out_data == $past(col2));

    assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && !in_hit) |=> pix_out_data == $past(pix_in_data[PIX_W-1:0]));

    assert_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_in_valid |=> pix_out_valid);

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_in_valid |=> !pix_out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_in_valid |=> $stable(pix_out_data));

    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == MASK_ADDR) |=> mask == $past(reg_wdata[PIX_W-1:0]));
endmodule

bind cursor_key_subst ckey_checker #(
    .PIX_W(PIX_W), .WORD_W(WORD_W), .REG_W(REG_W),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_in_valid(pix_in_valid), .pix_in_data(pix_in_data),
    .pix_out_valid(pix_out_valid), .pix_out_data(pix_out_data),
    .key(cfg_key), .mask(cfg_mask), .col1(cfg_col1), .col2(cfg_col2),
    .pos(cfg_pos)
);

// File: tb/cursor_key_subst_bench.sv
// Bench: behavioural reference model compared every clock.
module cursor_key_subst_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_in_valid = 1'b0;
    logic [31:0] pix_in_data = '0;
    logic        pix_out_valid;
    logic [23:0] pix_out_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model state
    logic [23:0] m_key = 0, m_mask = 0, m_c1 = 0, m_c2 = 0;
    logic [4:0]  m_pos = 0;
    logic        e_valid = 0;
    logic [23:0] e_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cursor_key_subst u_cursor_key_subst (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_in_valid(pix_in_valid), .pix_in_data(pix_in_data),
        .pix_out_valid(pix_out_valid), .pix_out_data(pix_out_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model_pix(input logic [31:0] w);
        if (((w[23:0] ^ m_key) & m_mask) != 0) return w[23:0];
        return w[m_pos] ? m_c2 : m_c1;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h50:   return {3'b000, m_pos, m_key};
            8'h54:   return {8'h00, m_mask};
            8'h58:   return {8'h00, m_c1};
            8'h5C:   return {8'h00, m_c2};
            default: return 32'h0;
        endcase
    endfunction

    // One clock: drive, predict, update model, then check after the edge
    task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                       input bit v, input logic [31:0] p, input string tag);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        pix_in_valid = v; pix_in_data = p;
        e_valid = v;
        if (v) e_data = model_pix(p);
        if (wr) begin
            case (a)
                8'h50: begin m_key = wd[23:0]; m_pos = wd[28:24]; end
                8'h54: m_mask = wd[23:0];
                8'h58: m_c1 = wd[23:0];
                8'h5C: m_c2 = wd[23:0];
                default: ;
            endcase
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        reg_wr = 1'b0; pix_in_valid = 1'b0;
        chk({tag, " valid"}, {31'b0, pix_out_valid}, {31'b0, e_valid});
        chk({tag, " data"}, {8'b0, pix_out_data}, {8'b0, e_data});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd);
        cyc(1, a, wd, 0, 0, "R8 write idle");
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, model_read(a));
    endtask

    task automatic px(input logic [31:0] p, input string tag);
        cyc(0, 8'h00, 0, 1, p, tag);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R1 out valid", {31'b0, pix_out_valid}, 0);
        chk("R1 out data", {8'b0, pix_out_data}, 0);
        rst_n = 1'b1;
        rd(8'h50, "R1 ctrl"); rd(8'h54, "R1 mask");
        rd(8'h58, "R1 col1"); rd(8'h5C, "R1 col2");

        // R2: register map and undefined bits
        wr(8'h50, 32'hFF123456);
        wr(8'h54, 32'hABFFFFFF);
        wr(8'h58, 32'h11AA0000);
        wr(8'h5C, 32'h2200BB00);
        rd(8'h50, "R2 ctrl rsvd"); rd(8'h54, "R2 mask");
        rd(8'h58, "R2 col1"); rd(8'h5C, "R2 col2");
        wr(8'h60, 32'hFFFFFFFF);
        wr(8'h52, 32'hFFFFFFFF);
        rd(8'h60, "R2 unmapped"); rd(8'h52, "R2 unaligned");
        rd(8'h50, "R2 ctrl kept"); rd(8'h58, "R2 col1 kept");

        // Position field is 31 from the write above
        wr(8'h50, 32'h00123456);                    // pos 0
        px(32'h00123456, "R4 exact match bit0=0");
        px(32'h00123457, "R6 miss low bit");
        px(32'h00654321, "R6 miss");
        wr(8'h50, 32'h1F123456);                    // pos 31
        px(32'h80123456, "R5 match bit31=1");
        px(32'h7F123456, "R4 match bit31=0");
        // R3: partial mask, only red byte compared
        wr(8'h54, 32'h00FF0000);
        wr(8'h50, 32'h18120000);                    // pos 24
        px(32'h0112ABCD, "R3 R5 masked match upper byte bit24");
        px(32'h0012ABCD, "R3 R4 masked match bit24=0");
        px(32'h0113ABCD, "R3 R6 masked miss");
        // R10: mask zero
        wr(8'h54, 32'h0);
        wr(8'h50, 32'h03000000);                    // pos 3
        px(32'h00000008, "R10 R5 all match");
        px(32'h00FFFFF0, "R10 R4 all match");
        // R7/R8: gap then back
        cyc(0, 8'h00, 0, 0, 32'h00FFFFFF, "R8 hold");
        cyc(0, 8'h00, 0, 0, 32'h00FFFF08, "R7 R8 idle");
        px(32'h00000000, "R7 resume");
        // R9: write with pixel in same cycle
        cyc(1, 8'h58, 32'h00C0FFEE, 1, 32'h00000000, "R9 old color same cycle");
        px(32'h00000000, "R9 new color next");
        cyc(1, 8'h54, 32'h00FFFFFF, 1, 32'h00000001, "R9 old mask same cycle");
        px(32'h00000001, "R9 new mask next");

        // Random traffic against the model
        wr(8'h54, 32'h00000303);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 0) begin
                logic [7:0] a;
                a = 8'h50 + {4'b0, r[5:4], 2'b00};
                cyc(1, a, $urandom & ((a == 8'h54) ? 32'hFFFF0F0F : 32'hFFFFFFFF),
                    r[6], $urandom, "R3 R4 R5 R6 R9 random");
            end else begin
                cyc(0, 8'h00, 0, r[7] | r[8], $urandom, "R3 R4 R5 R6 R7 random");
            end
            rd(r[9] ? 8'h50 : 8'h5C, "R2 random read");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule